// File: doc/BRIEF.md
# Request/Response Mailbox Register Block

This block is a small register file, reached through a byte-enabled register bus, that carries request/response data objects between software and a protocol responder. Software loads a request one dword at a time through a write-data register and then sets a start bit in the control register. The block checks the request length, hands the request to an external responder through a start/done handshake, and collects the response dwords the responder pushes back. Software then reads the response through a read-data register and acknowledges each dword by writing that same register.

The control register also provides an abort bit, which returns the mailbox to idle from any state, and an interrupt-enable bit. The status register reports busy, error, data-ready and interrupt status. The interrupt is a one-cycle pulse. It is raised when a response becomes ready or an error occurs, and only while the interrupt-status bit is clear. Software clears that bit by writing 1 to it.

Top module: `doe_mailbox`

## Requirements
- R1: After reset, a read of the capabilities register (offset 0x04) returns interrupt-supported in bit 0 and the vector number in bits 11:1. Control (0x08), status (0x0C) and read-data (0x14) all read 0. A control read returns only interrupt enable (bit 1); abort (bit 0) and start (bit 31) always read 0.
- R2: A write to the write-data register (0x10) with all four byte enables set appends the dword to the request and increments the request count. A write with fewer byte enables is ignored. The count never exceeds the mailbox depth.
- R3: Writing start (control bit 31, byte enable 3) checks the request. The request is passed to the responder, with busy (status bit 0) set until the responder finishes, only when it holds at least 2 dwords and bits 17:0 of dword 1 equal the count. Any other request is discarded and both mailboxes are emptied.
- R4: Start is ignored while error is set, and also while busy or ready is set.
- R5: When the responder signals done with success, data-ready (status bit 31) is set. When it signals done with failure, both mailboxes are emptied and ready stays 0. Busy and ready are never set together.
- R6: A full-dword read of read-data returns the current response dword only while ready=1 and error=0, and returns 0 otherwise. A read with fewer than four byte enables returns 0. Reads never advance the response.
- R7: A full-dword write to read-data advances the response index. When the index reaches the response length, both mailboxes are emptied and ready drops. Advancing beyond the length sets error (status bit 2).
- R8: A control write with abort (bit 0, byte enable 0) set clears ready, error and busy and empties both mailboxes. The other bits of that write, including start and interrupt enable, have no effect.
- R9: When the block supports interrupts and interrupt enable is 1, a ready or error event with interrupt status (status bit 1) at 0 sets interrupt status and produces a one-cycle pulse on irq_pulse. No pulse is produced while interrupt status is 1.
- R10: Writing 1 to status bit 1 with byte enable 0 set clears interrupt status.
- R11: Interrupt enable is written only by a control write whose byte enable 0 is set. A write that does not cover the low byte leaves interrupt enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset from the capability base |
| reg_be | input | 4 | Byte enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as reg_rd |
| req_start | output | 1 | One-cycle pulse: a request is ready for the responder |
| req_len | output | $clog2(DEPTH+1) | Number of request dwords |
| req_idx | input | $clog2(DEPTH) | Request dword index chosen by the responder |
| req_dword | output | 32 | Request dword at req_idx |
| rsp_valid | input | 1 | Responder pushes rsp_data into the response mailbox |
| rsp_data | input | 32 | Response dword |
| req_done | input | 1 | Responder has finished |
| req_ok | input | 1 | With req_done: 1 means success, 0 means discard |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The main exchange is tried with three kinds of request. A well-formed request must reach the responder and be echoed back. A request whose length field does not match its dword count must be discarded without a start pulse. A request the responder rejects must leave no response behind. A well-formed request sent right after a discard, a rejection or an abort checks that the request count was emptied: stale dwords would make the length check fail. A partial-width dword placed inside a request checks that partial writes are ignored, because an appended dword would change the count. Acknowledges past the end of a response, together with changes to interrupt enable and interrupt status, separate the ready and error interrupt paths from the case where interrupt status is already set.

// File: rtl/doe_mailbox.sv
module doe_mailbox #(
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 8,
  parameter bit INTR_SUP = 1'b1,
  parameter int IRQ_VEC  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [3:0]                 reg_be,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       req_start,
  output logic [$clog2(DEPTH+1)-1:0] req_len,
  input  logic [$clog2(DEPTH)-1:0]   req_idx,
  output logic [31:0]                req_dword,
  input  logic                       rsp_valid,
  input  logic [31:0]                rsp_data,
  input  logic                       req_done,
  input  logic                       req_ok,
  output logic                       irq_pulse
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_WDAT = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_RDAT = ADDR_W'(8'h14);

  logic [31:0]   wmb [DEPTH];
  logic [31:0]   rmb [DEPTH];
  logic [CW-1:0] wcnt, rlen;
  logic [CW:0]   ridx, ridx_nxt;
  logic          ien, busy, ready, err, irq_st, start_q, irq_q;

  wire full_dw  = reg_be == 4'hF;
  wire ctrl_wr  = reg_wr && reg_addr == A_CTRL;
  wire abort    = ctrl_wr && reg_be[0] && reg_wdata[0];
  wire go_try   = ctrl_wr && reg_be[3] && reg_wdata[31] && !abort;
  wire go       = go_try && !err && !busy && !ready;
  wire len_ok   = wcnt >= CW'(2) && wmb[1][17:0] == 18'(wcnt);
  wire go_run   = go && len_ok;
  wire go_drop  = go && !len_ok;
  wire done     = busy && req_done && !abort;
  wire done_ok  = done && req_ok;
  wire done_bad = done && !req_ok;
  wire wd_push  = reg_wr && reg_addr == A_WDAT && full_dw && wcnt < CW'(DEPTH);
  wire rs_push  = busy && rsp_valid && !abort && rlen < CW'(DEPTH);
  wire ack      = reg_wr && reg_addr == A_RDAT && full_dw;
  assign ridx_nxt = ridx + 1'b1;
  wire ack_end  = ack && ridx_nxt == {1'b0, rlen};
  wire ack_over = ack && ridx_nxt > {1'b0, rlen};
  wire flush    = abort || go_drop || done_bad || ack_end;
  wire irq_fire = INTR_SUP && ien && !irq_st && (done_ok || ack_over);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0; rlen <= '0; ridx <= '0;
      ien <= 1'b0; busy <= 1'b0; ready <= 1'b0; err <= 1'b0;
      irq_st <= 1'b0; start_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      start_q <= go_run;
      irq_q   <= irq_fire;
      if (ctrl_wr && reg_be[0] && !abort) ien <= reg_wdata[1];
      if (abort || done) busy <= 1'b0;
      else if (go_run)   busy <= 1'b1;
      if (flush)         ready <= 1'b0;
      else if (done_ok)  ready <= 1'b1;
      if (abort)         err <= 1'b0;
      else if (ack_over) err <= 1'b1;
      if (irq_fire)      irq_st <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_be[0] && reg_wdata[1]) irq_st <= 1'b0;
      if (flush)         wcnt <= '0;
      else if (wd_push)  wcnt <= wcnt + 1'b1;
      if (flush)         rlen <= '0;
      else if (rs_push)  rlen <= rlen + 1'b1;
      if (flush)         ridx <= '0;
      else if (ack && ridx <= (CW+1)'(DEPTH)) ridx <= ridx_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wd_push && !flush) wmb[wcnt[PW-1:0]] <= reg_wdata;
    if (rs_push)           rmb[rlen[PW-1:0]] <= rsp_data;
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CAP:  rd_mux = {20'b0, 11'(IRQ_VEC), INTR_SUP};
      A_CTRL: rd_mux = {30'b0, ien, 1'b0};
      A_STAT: rd_mux = {ready, 28'b0, err, irq_st, busy};
      A_RDAT: if (full_dw && ready && !err && ridx < {1'b0, rlen})
                rd_mux = rmb[ridx[PW-1:0]];
      default: rd_mux = '0;
    endcase
  end

  assign reg_rdata = reg_rd ? rd_mux : '0;
  assign req_start = start_q;
  assign req_len   = wcnt;
  assign req_dword = wmb[req_idx];
  assign irq_pulse = irq_q;

  AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) wcnt <= CW'(DEPTH)); // R2
  AST_GO_ERR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (go_try && err) |=> !req_start); // R4
  AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && ready)); // R5
  AST_ACK_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (ack && ready && ridx_nxt == {1'b0, rlen}) |=> !ready); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) abort |=> (!ready && !err && !busy && wcnt == '0 && rlen == '0)); // R8
  AST_IRQ_ON_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |-> (irq_st && !$past(irq_st))); // R9
endmodule

// File: tb/test_doe_mailbox.sv
module test_doe_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [7:0] CAP = 8'h04, CTRL = 8'h08, STAT = 8'h0C, WD = 8'h10, RDD = 8'h14;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_start, irq_pulse;
  logic [4:0] req_len;
  logic [3:0] req_idx = 0;
  logic [31:0] req_dword;
  logic rsp_valid = 0, req_done = 0, req_ok = 0;
  logic [31:0] rsp_data = 0;

  int nchk = 0, nfail = 0, irq_cnt = 0, start_cnt = 0;
  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  doe_mailbox #(.DEPTH(DEPTH)) i_doe_mailbox (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_start(req_start),
    .req_len(req_len), .req_idx(req_idx), .req_dword(req_dword), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .req_done(req_done), .req_ok(req_ok), .irq_pulse(irq_pulse));

  always @(negedge clk) begin
    if (rst_n && irq_pulse) irq_cnt++;
    if (rst_n && req_start) start_cnt++;
    if (reg_rd) begin
      item_t it;
      it = sb.pop_front();
      nchk++;
      if (reg_rdata !== it.exp) begin
        nfail++;
        $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (req_start) begin
        repeat (4) @(negedge clk);
        req_idx = 0; #1;
        if (req_dword == 32'h0000_0BAD) begin
          req_done = 1; req_ok = 0; @(negedge clk); req_done = 0;
        end else begin
          for (int i = 0; i < int'(req_len); i++) begin
            req_idx = 4'(i); #1;
            rsp_data = req_dword ^ 32'hFFFF_0000; rsp_valid = 1;
            @(negedge clk);
          end
          rsp_valid = 0; req_done = 1; req_ok = 1;
          @(negedge clk); req_done = 0;
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(posedge clk); #1 reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(posedge clk); #1 reg_wr = 0; reg_be = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag, input logic [3:0] be = 4'hF);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1 reg_rd = 1; reg_addr = a; reg_be = be;
    @(posedge clk); #1 reg_rd = 0; reg_be = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, e);
    end
  endtask

  task automatic settle();
    repeat (30) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_chk(CAP, 32'h0000_000B, "R1 capabilities");
    rd_chk(CTRL, 0, "R1 control reset");
    rd_chk(STAT, 0, "R1 status reset");
    rd_chk(RDD, 0, "R1 read data reset");
    wr(CTRL, 32'h2);
    rd_chk(CTRL, 32'h2, "R1 ien readback");

    wr(WD, 32'h0001_0000); wr(WD, 32'h3); wr(WD, 32'h1234);
    wr(CTRL, 32'h8000_0002);
    rd_chk(STAT, 32'h1, "R3 busy while processing");
    settle();
    rd_chk(STAT, 32'h8000_0002, "R5 ready after success");
    chk(irq_cnt == 1, "R9 irq on ready", irq_cnt, 1);
    rd_chk(CTRL, 32'h2, "R1 go reads zero");
    rd_chk(RDD, 32'hFFFE_0000, "R6 dword0");
    rd_chk(RDD, 32'hFFFE_0000, "R6 read does not advance");
    rd_chk(RDD, 0, "R6 partial read", 4'h1);
    wr(RDD, 0);
    rd_chk(RDD, 32'hFFFF_0003, "R7 dword1");
    wr(RDD, 0);
    rd_chk(RDD, 32'hFFFF_1234, "R7 dword2");
    wr(RDD, 0);
    rd_chk(STAT, 32'h2, "R7 ready drops at end");
    rd_chk(RDD, 0, "R6 zero when not ready");
    wr(STAT, 32'h2);
    rd_chk(STAT, 0, "R10 w1c");

    wr(RDD, 0);
    rd_chk(STAT, 32'h6, "R7 underflow error");
    chk(irq_cnt == 2, "R9 irq on error", irq_cnt, 2);
    wr(WD, 32'h0001_0000); wr(WD, 32'h2);
    wr(CTRL, 32'h8000_0002);
    settle();
    chk(start_cnt == 1, "R4 go ignored on error", start_cnt, 1);
    rd_chk(STAT, 32'h6, "R4 status unchanged");
    wr(CTRL, 32'h8000_0001);
    settle();
    rd_chk(STAT, 32'h2, "R8 abort clears error");
    rd_chk(CTRL, 32'h2, "R8 abort ignores ien bit");
    chk(start_cnt == 1, "R8 abort ignores go", start_cnt, 1);
    wr(STAT, 32'h2);

    wr(WD, 32'h0002_0000); wr(WD, 32'h2);
    wr(CTRL, 32'h8000_0002);
    settle();
    rd_chk(STAT, 32'h8000_0002, "R8 mailbox emptied by abort");
    chk(irq_cnt == 3, "R9 irq count", irq_cnt, 3);
    rd_chk(RDD, 32'hFFFD_0000, "R5 response0");
    wr(RDD, 0);
    rd_chk(RDD, 32'hFFFF_0002, "R5 response1");
    wr(RDD, 0);
    wr(STAT, 32'h2);

    wr(WD, 32'h0003_0000); wr(WD, 32'h5); wr(WD, 32'h77);
    wr(CTRL, 32'h8000_0002);
    settle();
    rd_chk(STAT, 0, "R3 length mismatch discarded");
    chk(start_cnt == 2, "R3 no start on mismatch", start_cnt, 2);

    wr(WD, 32'h0004_0000); wr(WD, 32'h0000_DEAD, 4'h3); wr(WD, 32'h2);
    wr(CTRL, 32'h8000_0002);
    settle();
    rd_chk(STAT, 32'h8000_0002, "R2 partial write ignored");
    rd_chk(RDD, 32'hFFFB_0000, "R2 response0");
    wr(RDD, 0);
    rd_chk(RDD, 32'hFFFF_0002, "R2 response1");
    wr(RDD, 0);
    wr(STAT, 32'h2);

    wr(WD, 32'h0000_0BAD); wr(WD, 32'h2);
    wr(CTRL, 32'h8000_0002);
    settle();
    rd_chk(STAT, 0, "R5 rejected request");
    chk(irq_cnt == 4, "R5 no irq on reject", irq_cnt, 4);

    wr(CTRL, 32'h0, 4'h2);
    rd_chk(CTRL, 32'h2, "R11 ien kept without low byte");
    wr(CTRL, 32'h0);
    rd_chk(CTRL, 32'h0, "R11 ien cleared");

    wr(WD, 32'h0005_0000); wr(WD, 32'h2);
    wr(CTRL, 32'h8000_0000);
    settle();
    rd_chk(STAT, 32'h8000_0000, "R9 no irq status when disabled");
    chk(irq_cnt == 4, "R9 no pulse when disabled", irq_cnt, 4);
    rd_chk(RDD, 32'hFFFA_0000, "R5 response after reject");
    wr(RDD, 0); wr(RDD, 0);
    rd_chk(STAT, 0, "R7 done");

    wr(CTRL, 32'h2);
    wr(RDD, 0);
    rd_chk(STAT, 32'h6, "R9 error irq");
    wr(RDD, 0);
    settle();
    chk(irq_cnt == 5, "R9 single pulse while status set", irq_cnt, 5);
    wr(CTRL, 32'h1);
    rd_chk(STAT, 32'h2, "R8 final abort");

    settle();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule